// File: doc/BRIEF.md
# Strapped-Address I2C Register Target

This block is the bus-facing front end of a small register-mapped device. It watches the two I2C lines through a fast system clock, removes short pulses from both, finds START and STOP conditions, and frames the traffic into bytes. It answers one 7-bit bus address. The upper five bits of that address are fixed. The two lower bits come from a strap pin that can be tied low, tied high or left floating.

A write sets an internal pointer from the register offset byte and then stores each later byte at the pointer, advancing it each time. A read begins with a repeated START and a read address. It returns bytes from the current pointer, advancing after each one, until the controller answers with a NACK. The register array sits outside the block and is reached through a write strobe and a combinational read port. SDA is driven open-drain through a single pull-low enable.

Top module: `i2c_strap_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `10110` followed by the two strap bits. The eighth bit (LSB) selects read (1) or write (0). The ACK is SDA held low during the ninth clock.
- R2: After reset the strap pin is sampled twice: with `strap_pu` high for STRAP_SETTLE cycles, then with `strap_pd` high for STRAP_SETTLE cycles. The two enables are never high together. Both samples low give strap value 0, both high give 1, and a disagreement (floating) gives 3.
- R3: A pulse on SCL or SDA that lasts GLITCH_NS or less has no effect on framing, data or detected conditions.
- R4: A falling SDA edge while SCL is high is a START. It restarts address framing from any state, including in the middle of a transfer (repeated START). A rising SDA edge while SCL is high is a STOP, which returns the target to idle.
- R5: After an address byte that does not match, the target drives nothing and writes nothing until the next START.
- R6: In a write, the byte after the address loads the register pointer. Each following byte gives one single-cycle `reg_we` pulse with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pointer then increments, wrapping at 2^AW. Every byte is acknowledged.
- R7: In a read, bytes are sent MSB first starting at the current pointer. The pointer advances by one after each byte.
- R8: A NACK from the controller after a read byte ends the transfer. SDA stays released until the next START.
- R9: `sda_oe` rises only while the filtered SCL is low, and a STOP leaves it low.
- R10: During reset and until strap sampling ends, `sda_oe` and `reg_we` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL pad level |
| sda_in | input | 1 | SDA pad level |
| sda_oe | output | 1 | Pull SDA low when high, release when low |
| strap_pad | input | 1 | Address strap pad level |
| strap_pu | output | 1 | Weak pull-up enable on the strap pad |
| strap_pd | output | 1 | Weak pull-down enable on the strap pad |
| reg_we | output | 1 | Register write strobe, one cycle |
| reg_addr | output | AW | Register pointer |
| reg_wdata | output | 8 | Byte to store |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
The bench uses the defaults: CLK_NS=10 and GLITCH_NS=50, which give a six-sample qualifier, so 5-cycle injected pulses sit exactly at the 50 ns limit. It also uses STRAP_SETTLE=8, so the two strap phases can be seen within a few dozen cycles of reset. AW=8 puts pointer wrap from 0xFF to 0x00 within reach of a two-byte write and a two-byte read. A slow bit phase of 25 cycles leaves room for the filter and synchroniser latency. With it, the bench covers all three strap settings, a mismatched address, a burst write, a burst read after a repeated START, and both kinds of injected glitch.

// File: rtl/i2c_strap_target.sv
module i2c_strap_target #(
  parameter int CLK_NS       = 10,
  parameter int GLITCH_NS    = 50,
  parameter int STRAP_SETTLE = 8,
  parameter int AW           = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          sda_oe,
  input  logic          strap_pad,
  output logic          strap_pu,
  output logic          strap_pd,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  input  logic [7:0]    reg_rdata
);
  localparam int FILT_CNT = GLITCH_NS / CLK_NS + 1;
  localparam int FW = $clog2(FILT_CNT + 1);
  localparam int SW = $clog2(2 * STRAP_SETTLE + 1);
  localparam logic [4:0] ADDR_HI = 5'b10110;

  logic [1:0] raw, filt, filt_q;
  assign raw = {sda_in, scl_in};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_flt
      logic s1, s2, f;
      logic [FW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          s1 <= 1'b1; s2 <= 1'b1; f <= 1'b1; cnt <= '0;
        end else begin
          s1 <= raw[g];
          s2 <= s1;
          if (s2 == f) cnt <= '0;
          else if (cnt == FW'(FILT_CNT - 1)) begin
            f   <= s2;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
      assign filt[g] = f;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) filt_q <= 2'b11;
    else        filt_q <= filt;

  logic scl_f, sda_f, scl_q, sda_q, start, stop, scl_rise, scl_fall;
  assign scl_f    = filt[0];
  assign sda_f    = filt[1];
  assign scl_q    = filt_q[0];
  assign sda_q    = filt_q[1];
  assign start    = scl_f & scl_q & sda_q & ~sda_f;
  assign stop     = scl_f & scl_q & ~sda_q & sda_f;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;

  logic [SW-1:0] scnt;
  logic up_v, dn_v, ready;
  logic [1:0] lsb;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scnt <= '0; up_v <= 1'b0; dn_v <= 1'b0;
    end else if (!ready) begin
      scnt <= scnt + 1'b1;
      if (scnt == SW'(STRAP_SETTLE - 1))     up_v <= strap_pad;
      if (scnt == SW'(2 * STRAP_SETTLE - 1)) dn_v <= strap_pad;
    end

  assign ready    = (scnt == SW'(2 * STRAP_SETTLE));
  assign strap_pu = (scnt < SW'(STRAP_SETTLE));
  assign strap_pd = !strap_pu && !ready;
  assign lsb      = (up_v == dn_v) ? {1'b0, up_v} : 2'b11;

  typedef enum logic [3:0] {
    IDLE, ADR, ADR_ACK, OFS, OFS_ACK, WR, WR_ACK, RD, RD_ACK
  } st_e;

  st_e state;
  logic [3:0] bitcnt;
  logic [7:0] sh, tx;
  logic rw, nack, we;
  logic [AW-1:0] ptr;

  assign reg_we    = we;
  assign reg_addr  = ptr;
  assign reg_wdata = sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= IDLE; bitcnt <= '0; sh <= '0; tx <= '0;
      rw <= 1'b0; nack <= 1'b0; we <= 1'b0; ptr <= '0; sda_oe <= 1'b0;
    end else begin
      we <= 1'b0;
      if (we) ptr <= ptr + 1'b1;
      if (!ready) state <= IDLE;
      else if (start) begin
        state <= ADR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop) begin
        state <= IDLE; sda_oe <= 1'b0;
      end else begin
        case (state)
          ADR, OFS, WR: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sh     <= {sh[6:0], sda_f};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (state == ADR) begin
                if (sh[7:1] == {ADDR_HI, lsb}) begin
                  sda_oe <= 1'b1; rw <= sh[0]; state <= ADR_ACK;
                end else state <= IDLE;
              end else if (state == OFS) begin
                ptr <= sh[AW-1:0]; sda_oe <= 1'b1; state <= OFS_ACK;
              end else begin
                we <= 1'b1; sda_oe <= 1'b1; state <= WR_ACK;
              end
            end
          end
          ADR_ACK, OFS_ACK, WR_ACK: begin
            if (scl_fall) begin
              if (state == ADR_ACK && rw) begin
                tx <= reg_rdata; sda_oe <= ~reg_rdata[7]; state <= RD;
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == ADR_ACK) ? OFS : WR;
              end
            end
          end
          RD: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0; ptr <= ptr + 1'b1; bitcnt <= '0; state <= RD_ACK;
              end else begin
                sda_oe <= ~tx[6]; tx <= {tx[6:0], 1'b0};
              end
            end
          end
          RD_ACK: begin
            if (scl_rise) nack <= sda_f;
            else if (scl_fall) begin
              if (nack) state <= IDLE;
              else begin
                tx <= reg_rdata; sda_oe <= ~reg_rdata[7]; bitcnt <= '0; state <= RD;
              end
            end
          end
          default: ;
        endcase
      end
    end
endmodule

// File: rtl/i2c_strap_target_chk.sv
module i2c_strap_target_chk #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sda_oe,
  input logic          strap_pu,
  input logic          strap_pd,
  input logic          reg_we,
  input logic [AW-1:0] reg_addr,
  input logic          scl_f,
  input logic          stop_det,
  input logic          ready
);
  assert_oe_rise_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);

  assert_stop_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  assert_we_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  assert_ptr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_addr == AW'($past(reg_addr) + 1'b1)));

  assert_strap_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(strap_pu && strap_pd));

  assert_quiet_before_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!sda_oe && !reg_we));
endmodule

bind i2c_strap_target i2c_strap_target_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .strap_pu(strap_pu),
  .strap_pd(strap_pd), .reg_we(reg_we), .reg_addr(reg_addr),
  .scl_f(filt[0]), .stop_det(stop), .ready(ready)
);

// File: tb/test_i2c_strap_target.sv
module test_i2c_strap_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic [1:0] strap_mode = 2'd2;
  logic sda_oe, strap_pu, strap_pd, reg_we, strap_pad;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic sda_line;
  int tests = 0, fails = 0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda_line  = sda_drv & ~sda_oe;
  assign strap_pad = (strap_mode == 2'd2) ? strap_pu : strap_mode[0];
  assign reg_rdata = mem[reg_addr];

  i2c_strap_target i_i2c_strap_target (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line), .sda_oe(sda_oe),
    .strap_pad(strap_pad), .strap_pu(strap_pu), .strap_pd(strap_pd),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      logic [15:0] e;
      if (exp_q.size() == 0) chk(1'b0, "R5/R6 unexpected write", {reg_addr, reg_wdata}, 0);
      else begin
        e = exp_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R6 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q); sda_drv = 1'b0; wq(Q); scl_drv = 1'b0;
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(Q); scl_drv = 1'b1; wq(Q); sda_drv = 1'b1; wq(2 * Q);
  endtask

  task automatic bit_out(input bit b, input int gk);
    wq(Q); sda_drv = b; wq(Q); scl_drv = 1'b1; wq(Q);
    if (gk == 1) begin scl_drv = 1'b0; wq(5); scl_drv = 1'b1; end
    if (gk == 2) begin sda_drv = ~b; wq(5); sda_drv = b; end
    wq(Q); scl_drv = 1'b0;
  endtask

  task automatic bit_in(output bit b);
    wq(Q); sda_drv = 1'b1; wq(Q); scl_drv = 1'b1; wq(Q); b = sda_line; wq(Q); scl_drv = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, input int gbit, input int gk, output bit ack);
    bit a;
    for (int i = 7; i >= 0; i--) bit_out(d[i], (i == gbit) ? gk : 0);
    bit_in(a);
    ack = !a;
  endtask

  task automatic rbyte(output logic [7:0] d, input bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(!ack, 0);
  endtask

  task automatic expect_ack(input logic [7:0] d, input bit exp, input string req);
    bit a;
    wbyte(d, -1, 0, a);
    chk(a == exp, req, a, exp);
  endtask

  task automatic expect_read(input logic [7:0] exp, input bit ack, input string req);
    logic [7:0] d;
    rbyte(d, ack);
    chk(d == exp, req, d, exp);
  endtask

  task automatic do_reset(input logic [1:0] mode);
    rst_n = 1'b0; strap_mode = mode; scl_drv = 1'b1; sda_drv = 1'b1;
    wq(5);
    chk(sda_oe == 1'b0 && reg_we == 1'b0, "R10 reset outputs quiet", {sda_oe, reg_we}, 0);
    rst_n = 1'b1;
    wq(3);
    chk(strap_pu && !strap_pd, "R2 pull-up phase", {strap_pu, strap_pd}, 2'b10);
    chk(sda_oe == 1'b0, "R10 no drive while sampling", sda_oe, 0);
    wq(9);
    chk(!strap_pu && strap_pd, "R2 pull-down phase", {strap_pu, strap_pd}, 2'b01);
    wq(10);
    chk(!strap_pu && !strap_pd, "R2 pulls off after sampling", {strap_pu, strap_pd}, 0);
  endtask

  initial begin
    bit a;
    foreach (mem[i]) mem[i] = 8'h00;
    do_reset(2'd2);

    bus_start();
    expect_ack(8'hB4, 1'b0, "R5 mismatched address NACK");
    expect_ack(8'h10, 1'b0, "R5 stays idle after mismatch");
    expect_ack(8'h33, 1'b0, "R5 stays idle after mismatch");
    bus_stop();

    bus_start();
    expect_ack(8'hB6, 1'b1, "R1 floating strap address 0x5B ACK");
    expect_ack(8'h10, 1'b1, "R6 offset ACK");
    exp_q.push_back({8'h10, 8'hA5}); expect_ack(8'hA5, 1'b1, "R6 data ACK");
    exp_q.push_back({8'h11, 8'h3C}); expect_ack(8'h3C, 1'b1, "R6 data ACK");
    exp_q.push_back({8'h12, 8'h7E}); expect_ack(8'h7E, 1'b1, "R6 data ACK");
    bus_stop();

    bus_start();
    expect_ack(8'hB6, 1'b1, "R1 address ACK");
    expect_ack(8'h10, 1'b1, "R6 offset ACK");
    bus_start();
    expect_ack(8'hB7, 1'b1, "R4 repeated START read address ACK");
    expect_read(8'hA5, 1'b1, "R7 read byte 0");
    expect_read(8'h3C, 1'b1, "R7 read byte 1");
    expect_read(8'h7E, 1'b0, "R7 read byte 2");
    for (int k = 0; k < 4; k++) begin
      wq(Q);
      chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
    end
    scl_drv = 1'b1; wq(Q);
    chk(sda_oe == 1'b0, "R8 idle after NACK", sda_oe, 0);
    scl_drv = 1'b0;
    bus_stop();

    bus_start();
    expect_ack(8'hB6, 1'b1, "R1 address ACK");
    expect_ack(8'h40, 1'b1, "R6 offset ACK");
    exp_q.push_back({8'h40, 8'h96});
    wbyte(8'h96, 4, 1, a); chk(a, "R3 SCL glitch ignored ACK", a, 1);
    exp_q.push_back({8'h41, 8'h69});
    wbyte(8'h69, 1, 2, a); chk(a, "R3 SDA glitch ignored ACK", a, 1);
    bus_stop();
    bus_start();
    expect_ack(8'hB6, 1'b1, "R1 address ACK");
    expect_ack(8'h40, 1'b1, "R6 offset ACK");
    bus_start();
    expect_ack(8'hB7, 1'b1, "R4 repeated START");
    expect_read(8'h96, 1'b1, "R3 byte after SCL glitch");
    expect_read(8'h69, 1'b0, "R3 byte after SDA glitch");
    bus_stop();

    bus_start();
    expect_ack(8'hB6, 1'b1, "R1 address ACK");
    expect_ack(8'hFF, 1'b1, "R6 offset ACK");
    exp_q.push_back({8'hFF, 8'hC3}); expect_ack(8'hC3, 1'b1, "R6 data ACK");
    exp_q.push_back({8'h00, 8'h5A}); expect_ack(8'h5A, 1'b1, "R6 wrapped data ACK");
    bus_start();
    expect_ack(8'hB6, 1'b1, "R4 repeated START write");
    expect_ack(8'hFF, 1'b1, "R6 offset ACK");
    bus_start();
    expect_ack(8'hB7, 1'b1, "R4 repeated START read");
    expect_read(8'hC3, 1'b1, "R7 read at 0xFF");
    expect_read(8'h5A, 1'b0, "R7 read wraps to 0x00");
    bus_stop();

    do_reset(2'd0);
    bus_start();
    expect_ack(8'hB6, 1'b0, "R2 low strap rejects 0x5B");
    bus_stop();
    bus_start();
    expect_ack(8'hB0, 1'b1, "R2 low strap address 0x58 ACK");
    expect_ack(8'h20, 1'b1, "R6 offset ACK");
    exp_q.push_back({8'h20, 8'h11}); expect_ack(8'h11, 1'b1, "R6 data ACK");
    bus_stop();

    do_reset(2'd1);
    bus_start();
    expect_ack(8'hB0, 1'b0, "R2 high strap rejects 0x58");
    bus_stop();
    bus_start();
    expect_ack(8'hB2, 1'b1, "R2 high strap address 0x59 ACK");
    expect_ack(8'h20, 1'b1, "R6 offset ACK");
    bus_start();
    expect_ack(8'hB3, 1'b1, "R4 repeated START read");
    expect_read(8'h11, 1'b0, "R7 read back");
    bus_stop();

    chk(exp_q.size() == 0, "R6 all expected writes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog R4 run hung actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule